// File: doc/BRIEF.md
# ECC Error Logging Register Bank

This block sits next to the ECC checker of a DRAM controller and records what that checker finds. The checker sends a one-cycle pulse for each correctable or uncorrectable error, along with the failing address. The bank counts each error class separately. It keeps the most recent correctable address and the earliest uncorrectable address since the last clear. It drives a level interrupt that stays high until software clears the logged state.

Software reaches the bank through a 32-bit register port with byte offsets on a 4-byte stride. Reads take effect in the same cycle. Writes take effect at the next clock edge. Configuration and control writes are accepted only after a protection key has been written. Writing any other value to the key register closes the bank again.

Top module: `ecc_errlog_regs`

## Requirements
- R1: After reset the bank is locked, the key, configuration, interrupt control/status and both address registers read 0, and `irq` is low.
- R2: Writing 32'hFC600309 to offset 0x00 unlocks the bank, and writing any other value there locks it. Bit 0 of offset 0x00 reads 1 while unlocked and 0 while locked. All other bits of offset 0x00 read 0.
- R3: While the bank is locked, writes to offsets 0x04 and 0x50 leave every register unchanged. Reads are served whether the bank is locked or not, and offset 0x00 accepts writes in both states.
- R4: Offset 0x04 holds a writable ECC-enable bit at bit 7 and a DRAM-type bit at bit 4 (1 = DDR4, 0 = DDR3). All other bits of offset 0x04 read 0.
- R5: The correctable count reads at bits [23:16] of offset 0x50. It rises by one per `ce_evt` pulse and holds at 255.
- R6: The uncorrectable count reads at bits [15:12] of offset 0x50. It rises by one per `ue_evt` pulse and holds at 15.
- R7: Offset 0x58 returns the address of the first uncorrectable error since reset or the last clear. Later uncorrectable errors do not change it.
- R8: Offset 0x5C returns the address of the latest correctable error.
- R9: At offset 0x50, bit 0 enables the correctable interrupt and bit 1 enables the uncorrectable interrupt. `irq` is high whenever an enabled class has a nonzero count. It stays high with no further events.
- R10: Bit 31 of offset 0x50 is a clear control and reads back as written. While it is set, both counts and both addresses are held at 0, the first-address capture is re-armed, and an error pulse arriving in that cycle is discarded. `irq` is low in the cycle after clear is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_off | input | 7 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the offset |
| ce_evt | input | 1 | Correctable error pulse |
| ce_evt_addr | input | EVT_ADDR_W | Address of the correctable error |
| ue_evt | input | 1 | Uncorrectable error pulse |
| ue_evt_addr | input | EVT_ADDR_W | Address of the uncorrectable error |
| irq | output | 1 | Level interrupt, active high |

## Verification
Most internal faults in this bank show up at the ports within one cycle. A wrong lock state shows at once as a lock bit that reads wrongly at offset 0x00. It also shows as a configuration or control value that changes when it should not; this is visible in the first read after the write. A capture register that fails to hold, or fails to re-arm, shows on the next read of 0x58 after a second uncorrectable pulse or after a clear. A counter that wraps instead of holding only becomes visible after 16 or 256 pulses, so the saturation runs go past both limits. A clear that loses to a coincident pulse leaves a nonzero count and a raised `irq` one cycle later.

// File: rtl/ecc_errlog_pkg.sv
package ecc_errlog_pkg;
    localparam int REG_W    = 32;
    localparam int OFF_W    = 7;
    localparam int CE_CNT_W = 8;
    localparam int UE_CNT_W = 4;

    localparam logic [REG_W-1:0] UNLOCK_KEY = 32'hFC600309;

    localparam logic [OFF_W-1:0] OFF_KEY     = 7'h00;
    localparam logic [OFF_W-1:0] OFF_CFG     = 7'h04;
    localparam logic [OFF_W-1:0] OFF_ISR     = 7'h50;
    localparam logic [OFF_W-1:0] OFF_UE_ADDR = 7'h58;
    localparam logic [OFF_W-1:0] OFF_CE_ADDR = 7'h5C;

    localparam int CFG_ECC_BIT  = 7;
    localparam int CFG_DDR4_BIT = 4;
    localparam int ISR_CLR_BIT  = 31;
    localparam int ISR_CE_LSB   = 16;
    localparam int ISR_UE_LSB   = 12;
    localparam int IEN_CE_BIT   = 0;
    localparam int IEN_UE_BIT   = 1;

    typedef enum logic {
        CAP_FIRST = 1'b0,
        CAP_LAST  = 1'b1
    } cap_mode_e;

    typedef struct packed {
        logic ecc_en;
        logic ddr4;
        logic clr;
        logic ien_ce;
        logic ien_ue;
    } ctl_t;
endpackage

// File: rtl/errlog_lock.sv
module errlog_lock
    import ecc_errlog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [REG_W-1:0] key_val,
    output logic             unlocked_o
);
    logic unlocked_d, unlocked_q;

    always_comb begin
        unlocked_d = unlocked_q;
        if (key_wr) begin
            unlocked_d = (key_val == UNLOCK_KEY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) unlocked_q <= 1'b0;
        else        unlocked_q <= unlocked_d;
    end

    assign unlocked_o = unlocked_q;
endmodule

// File: rtl/errlog_sat_counter.sv
module errlog_sat_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clr) begin
            count_d = '0;
        end else if (inc && (count_q != CNT_MAX)) begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count_o = count_q;

    // R5 and R6: a full counter stays full
    assert_count_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CNT_MAX && !clr) |=> (count_q == CNT_MAX));

    // R5 and R6: each pulse below the limit adds exactly one
    assert_count_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && count_q != CNT_MAX) |=> (count_q == $past(count_q) + 1'b1));

    // R10: clear dominates a coincident pulse
    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count_q == '0));
endmodule

// File: rtl/errlog_addr_capture.sv
module errlog_addr_capture
    import ecc_errlog_pkg::*;
#(
    parameter int        ADDR_W = 32,
    parameter cap_mode_e MODE   = CAP_LAST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              evt,
    input  logic [ADDR_W-1:0] evt_addr,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] addr_d, addr_q;

    generate
        if (MODE == CAP_FIRST) begin : g_first
            logic held_d, held_q;

            always_comb begin
                addr_d = addr_q;
                held_d = held_q;
                if (clr) begin
                    addr_d = '0;
                    held_d = 1'b0;
                end else if (evt && !held_q) begin
                    addr_d = evt_addr;
                    held_d = 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) held_q <= 1'b0;
                else        held_q <= held_d;
            end

            // R7: once an address is held, only a clear can change it
            assert_first_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (held_q && !clr) |=> $stable(addr_q));
        end else begin : g_last
            always_comb begin
                addr_d = addr_q;
                if (clr) begin
                    addr_d = '0;
                end else if (evt) begin
                    addr_d = evt_addr;
                end
            end

            // R8: every event overwrites the stored address
            assert_last_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (evt && !clr) |=> (addr_q == $past(evt_addr)));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr_o = addr_q;
endmodule

// File: rtl/ecc_errlog_regs.sv
module ecc_errlog_regs
    import ecc_errlog_pkg::*;
#(
    parameter int EVT_ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [OFF_W-1:0]      bus_off,
    input  logic [REG_W-1:0]      bus_wdata,
    output logic [REG_W-1:0]      bus_rdata,
    input  logic                  ce_evt,
    input  logic [EVT_ADDR_W-1:0] ce_evt_addr,
    input  logic                  ue_evt,
    input  logic [EVT_ADDR_W-1:0] ue_evt_addr,
    output logic                  irq
);
    ctl_t ctl_d, ctl_q;

    logic                  unlocked;
    logic                  wr_any;
    logic                  wr_ok;
    logic [CE_CNT_W-1:0]   ce_cnt;
    logic [UE_CNT_W-1:0]   ue_cnt;
    logic [EVT_ADDR_W-1:0] ce_addr;
    logic [EVT_ADDR_W-1:0] ue_addr;
    logic                  irq_d, irq_q;

    assign wr_any = bus_sel && bus_wr;
    assign wr_ok  = wr_any && unlocked;

    errlog_lock u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_wr     (wr_any && (bus_off == OFF_KEY)),
        .key_val    (bus_wdata),
        .unlocked_o (unlocked)
    );

    errlog_sat_counter #(.CNT_W(CE_CNT_W)) u_ce_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ctl_q.clr),
        .inc     (ce_evt),
        .count_o (ce_cnt)
    );

    errlog_sat_counter #(.CNT_W(UE_CNT_W)) u_ue_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ctl_q.clr),
        .inc     (ue_evt),
        .count_o (ue_cnt)
    );

    errlog_addr_capture #(.ADDR_W(EVT_ADDR_W), .MODE(CAP_LAST)) u_ce_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ctl_q.clr),
        .evt      (ce_evt),
        .evt_addr (ce_evt_addr),
        .addr_o   (ce_addr)
    );

    errlog_addr_capture #(.ADDR_W(EVT_ADDR_W), .MODE(CAP_FIRST)) u_ue_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ctl_q.clr),
        .evt      (ue_evt),
        .evt_addr (ue_evt_addr),
        .addr_o   (ue_addr)
    );

    // next-state of the control fields
    always_comb begin
        ctl_d = ctl_q;
        if (wr_ok && (bus_off == OFF_CFG)) begin
            ctl_d.ecc_en = bus_wdata[CFG_ECC_BIT];
            ctl_d.ddr4   = bus_wdata[CFG_DDR4_BIT];
        end
        if (wr_ok && (bus_off == OFF_ISR)) begin
            ctl_d.clr    = bus_wdata[ISR_CLR_BIT];
            ctl_d.ien_ce = bus_wdata[IEN_CE_BIT];
            ctl_d.ien_ue = bus_wdata[IEN_UE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // interrupt level follows the logged state
    always_comb begin
        irq_d = (ctl_q.ien_ce && (ce_cnt != '0)) || (ctl_q.ien_ue && (ue_cnt != '0));
    end

    assign irq_q = irq_d;
    assign irq   = irq_q;

    // read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_off)
            OFF_KEY: bus_rdata[0] = unlocked;
            OFF_CFG: begin
                bus_rdata[CFG_ECC_BIT]  = ctl_q.ecc_en;
                bus_rdata[CFG_DDR4_BIT] = ctl_q.ddr4;
            end
            OFF_ISR: begin
                bus_rdata[ISR_CLR_BIT]                       = ctl_q.clr;
                bus_rdata[ISR_CE_LSB +: CE_CNT_W]            = ce_cnt;
                bus_rdata[ISR_UE_LSB +: UE_CNT_W]            = ue_cnt;
                bus_rdata[IEN_CE_BIT]                        = ctl_q.ien_ce;
                bus_rdata[IEN_UE_BIT]                        = ctl_q.ien_ue;
            end
            OFF_UE_ADDR: bus_rdata = REG_W'(ue_addr);
            OFF_CE_ADDR: bus_rdata = REG_W'(ce_addr);
            default:     bus_rdata = '0;
        endcase
    end

    // R3: a locked bank ignores control writes
    assert_locked_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && !unlocked && bus_off != OFF_KEY) |=> $stable(ctl_q));

    // R2: the key opens the bank on the next cycle
    assert_key_unlocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_off == OFF_KEY && bus_wdata == UNLOCK_KEY) |=> unlocked);

    // R10: the cycle after a clear is seen, the interrupt is quiet
    assert_clear_quiets_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.clr |=> !irq);

    // R9: with both enables low there is no interrupt
    assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.ien_ce && !ctl_q.ien_ue) |-> !irq);
endmodule

// File: tb/ecc_errlog_regs_tb_top.sv
module ecc_errlog_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV         = 21;
    localparam logic [31:0] KEY = 32'hFC600309;

    typedef struct packed {
        logic        is_rd;
        logic [6:0]  off;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    // register-level vectors, no error events
    localparam vec_t VECS [NV] = '{
        '{1'b1, 7'h00, 32'h0,         32'h0,        8'd1},  // R1 key reg
        '{1'b1, 7'h04, 32'h0,         32'h0,        8'd1},  // R1 config
        '{1'b1, 7'h50, 32'h0,         32'h0,        8'd1},  // R1 control/status
        '{1'b1, 7'h58, 32'h0,         32'h0,        8'd1},  // R1 ue addr
        '{1'b0, 7'h04, 32'h00000090,  32'h0,        8'd3},  // R3 locked write
        '{1'b1, 7'h04, 32'h0,         32'h0,        8'd3},
        '{1'b0, 7'h50, 32'h80000003,  32'h0,        8'd3},
        '{1'b1, 7'h50, 32'h0,         32'h0,        8'd3},
        '{1'b0, 7'h00, KEY,           32'h0,        8'd2},  // R2 unlock
        '{1'b1, 7'h00, 32'h0,         32'h1,        8'd2},
        '{1'b0, 7'h04, 32'hFFFFFFFF,  32'h0,        8'd4},  // R4 only two bits stick
        '{1'b1, 7'h04, 32'h0,         32'h90,       8'd4},
        '{1'b0, 7'h04, 32'h00000080,  32'h0,        8'd4},
        '{1'b1, 7'h04, 32'h0,         32'h80,       8'd4},
        '{1'b0, 7'h00, ~KEY,          32'h0,        8'd2},  // R2 complement relocks
        '{1'b1, 7'h00, 32'h0,         32'h0,        8'd2},
        '{1'b0, 7'h04, 32'h00000010,  32'h0,        8'd3},  // R3 ignored again
        '{1'b1, 7'h04, 32'h0,         32'h80,       8'd3},
        '{1'b0, 7'h00, KEY,           32'h0,        8'd2},
        '{1'b0, 7'h04, 32'h00000010,  32'h0,        8'd4},  // R4 DDR4 select
        '{1'b1, 7'h04, 32'h0,         32'h10,       8'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_off = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ce_evt = 1'b0;
    logic [31:0] ce_evt_addr = '0;
    logic        ue_evt = 1'b0;
    logic [31:0] ue_evt_addr = '0;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_errlog_regs #(.EVT_ADDR_W(32)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_off     (bus_off),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .ce_evt      (ce_evt),
        .ce_evt_addr (ce_evt_addr),
        .ue_evt      (ue_evt),
        .ue_evt_addr (ue_evt_addr),
        .irq         (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] off, input logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_off = off; bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [6:0] off, input logic [31:0] exp);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_off = off;
        #1;
        check(req, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic ce_pulse(input logic [31:0] a);
        @(negedge clk);
        ce_evt = 1'b1; ce_evt_addr = a;
        @(negedge clk);
        ce_evt = 1'b0;
    endtask

    task automatic ue_pulse(input logic [31:0] a);
        @(negedge clk);
        ue_evt = 1'b1; ue_evt_addr = a;
        @(negedge clk);
        ue_evt = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 irq", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_rd) begin
                rd_check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].off, VECS[i].exp);
            end else begin
                wr(VECS[i].off, VECS[i].data);
            end
        end

        // bank is unlocked here; enable both interrupt classes
        wr(7'h50, 32'h00000003);
        check("R9 no irq without errors", {31'b0, irq}, 32'h0);

        // R8: latest correctable address, R5: counting
        ce_pulse(32'h1000_0010);
        check("R9 irq after ce", {31'b0, irq}, 32'h1);
        ce_pulse(32'h1000_0020);
        ce_pulse(32'h1000_0030);
        rd_check("R8 last ce addr", 7'h5C, 32'h1000_0030);
        rd_check("R5 ce count 3", 7'h50, 32'h0003_0003);

        // R7: first uncorrectable address held
        ue_pulse(32'h2000_0100);
        ue_pulse(32'h2000_0200);
        rd_check("R7 first ue addr", 7'h58, 32'h2000_0100);
        rd_check("R6 ue count 2", 7'h50, 32'h0003_2003);
        repeat (5) @(negedge clk);
        check("R9 irq level holds", {31'b0, irq}, 32'h1);

        // R3: locked clear write ignored
        wr(7'h00, 32'h0);
        wr(7'h50, 32'h80000000);
        rd_check("R3 locked clear ignored", 7'h50, 32'h0003_2003);
        wr(7'h00, KEY);

        // R10: clear, with a coincident correctable pulse
        wr(7'h50, 32'h80000003);
        ce_pulse(32'h1000_0040);
        rd_check("R10 counts cleared", 7'h50, 32'h8000_0003);
        check("R10 irq low", {31'b0, irq}, 32'h0);
        rd_check("R10 ce addr cleared", 7'h5C, 32'h0);
        rd_check("R10 ue addr cleared", 7'h58, 32'h0);
        wr(7'h50, 32'h00000003);
        ue_pulse(32'h2000_0300);
        rd_check("R7 rearmed after clear", 7'h58, 32'h2000_0300);

        // R6 saturation
        @(negedge clk);
        ue_evt = 1'b1; ue_evt_addr = 32'h2000_0400;
        repeat (20) @(negedge clk);
        ue_evt = 1'b0;
        rd_check("R6 ue saturates at 15", 7'h50, 32'h0000_F003);
        rd_check("R7 still first", 7'h58, 32'h2000_0300);

        // R5 saturation
        @(negedge clk);
        ce_evt = 1'b1; ce_evt_addr = 32'h1000_0050;
        repeat (300) @(negedge clk);
        ce_evt = 1'b0;
        rd_check("R5 ce saturates at 255", 7'h50, 32'h00FF_F003);

        // R9: enables off silence irq with counts still nonzero
        wr(7'h50, 32'h00000000);
        check("R9 irq off when disabled", {31'b0, irq}, 32'h0);
        wr(7'h50, 32'h00000002);
        check("R9 ue enable alone", {31'b0, irq}, 32'h1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule